// File: doc/BRIEF.md
# Output Transition Timestamp Recorder

This engine drives one stimulus word onto a device under test and logs how the device's outputs move afterwards. Once per clock tick it samples the output bus. It stores an entry only when the sample differs from the sample of the tick before. Each entry pairs the tick count since the first sample with the new output value. Memory use therefore grows with the number of transitions and not with the length of the observation.

Capture stops in one of two ways. The first is a programmable run of ticks with no transition. The second is a transition that arrives when the event store is already full. The engine then streams a header and all stored entries out one byte at a time through a valid/ready byte port. When the last byte has been taken, it pulses done and goes back to idle. A new stimulus is taken only after that point. The internal tick counter is 32 bits wide and holds at its maximum instead of wrapping.

Top module: `xition_logger`

## Requirements
- R1: While reset is held and after it is released, `busy`, `tx_valid` and `done` are low and `dut_in` is zero.
- R2: A `start` seen while idle loads `stim` onto `dut_in` at that clock edge. `dut_in` then keeps that value until the next accepted start.
- R3: Every run stores a first entry with timestamp 0, holding the output sampled on the clock edge one cycle after the start edge.
- R4: The sample taken k cycles after the first sample has timestamp k. An entry is stored only when that sample differs from the sample one tick earlier. A sample equal to its predecessor adds no entry.
- R5: Capture ends on the sample that completes `quiet_lim` consecutive unchanged samples after the last stored change. A `quiet_lim` of 0 acts as 1. `tx_valid` rises on the next clock edge.
- R6: With DEPTH entries stored, the next differing sample ends capture without storing anything, and the overflow flag is set.
- R7: The stream is a 4-byte header followed by 8 bytes per entry, every field least significant byte first. The header carries the entry count in its low bits and the overflow flag in bit 31. Each entry sends its 32-bit timestamp and then its output value zero-extended to 32 bits. A byte moves on only on a clock edge with `tx_valid` and `tx_ready` both high. Otherwise it is held.
- R8: On the edge that takes the last byte, the block returns to idle and `done` is high for exactly one cycle.
- R9: `start` has no effect while the block is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to apply a new stimulus |
| stim | input | STIM_W | Stimulus word for the device under test |
| quiet_lim | input | QW | Unchanged ticks that end capture |
| dut_out | input | VAL_W | Outputs of the device under test |
| dut_in | output | STIM_W | Stimulus held on the device under test |
| tx_valid | output | 1 | A stream byte is offered |
| tx_byte | output | 8 | Stream byte |
| tx_ready | input | 1 | Consumer takes the offered byte |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse after the last byte |

## Verification
The start edge loads `dut_in`, so the bench reads it at the falling edge that follows. The first sample falls on the next rising edge and becomes timestamp 0. The sample on rising edge k+1 after the start carries timestamp k. The bench therefore changes `dut_out` on the falling edge before the sample it wants to move. The stream must begin exactly one edge after the tick that ends capture, and the bench checks `tx_valid` at the falling edge numbered end tick plus two. Bytes count as taken only on a falling edge where the bench has already set ready, and `done` is checked one edge after the last accepted byte.

// File: rtl/xl_pkg.sv
package xl_pkg;

  localparam int TS_W      = 32;
  localparam int HDR_BYTES = 4;
  localparam int ENT_BYTES = 8;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_APPLY   = 2'd1,
    ST_CAPTURE = 2'd2,
    ST_SEND    = 2'd3
  } xl_state_e;

  // Tick counter step that holds at all ones.
  function automatic logic [31:0] sat_inc(input logic [31:0] x);
    return (&x) ? x : x + 32'd1;
  endfunction

  // Bytes in a stream carrying n entries.
  function automatic int unsigned stream_len(input int unsigned n);
    return HDR_BYTES + ENT_BYTES * n;
  endfunction

  // Entry that holds a given stream byte.
  function automatic int unsigned entry_of(input int unsigned idx);
    return (idx < HDR_BYTES) ? 0 : (idx - HDR_BYTES) / ENT_BYTES;
  endfunction

  // Byte of the stream at position idx.
  function automatic logic [7:0] pick_byte(input int unsigned idx,
                                           input logic [31:0] hdr,
                                           input logic [31:0] ts,
                                           input logic [31:0] val);
    int unsigned k;
    logic [31:0] w;
    if (idx < HDR_BYTES) begin
      w = hdr;
      k = idx;
    end else begin
      k = (idx - HDR_BYTES) % ENT_BYTES;
      if (k < 4) begin
        w = ts;
      end else begin
        w = val;
        k = k - 4;
      end
    end
    return w[8*k +: 8];
  endfunction

endpackage

// File: rtl/xl_change_det.sv
module xl_change_det #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         track,
  input  logic         cmp,
  input  logic [W-1:0] sample,
  output logic         changed
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     prev_q <= '0;
    else if (track) prev_q <= sample;
  end

  assign changed = cmp && (sample != prev_q);
endmodule

// File: rtl/xl_event_ram.sv
module xl_event_ram #(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int TW    = 32,
  parameter int VW    = 16
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [TW-1:0] wr_ts,
  input  logic [VW-1:0] wr_val,
  input  logic [AW-1:0] rd_addr,
  output logic [TW-1:0] rd_ts,
  output logic [VW-1:0] rd_val
);
  logic [TW+VW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= {wr_ts, wr_val};
  end

  assign rd_ts  = mem[rd_addr][TW+VW-1:VW];
  assign rd_val = mem[rd_addr][VW-1:0];
endmodule

// File: rtl/xition_logger.sv
module xition_logger
  import xl_pkg::*;
#(
  parameter int STIM_W = 16,
  parameter int VAL_W  = 16,
  parameter int DEPTH  = 16,
  parameter int QW     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [STIM_W-1:0] stim,
  input  logic [QW-1:0]     quiet_lim,
  input  logic [VAL_W-1:0]  dut_out,
  output logic [STIM_W-1:0] dut_in,
  output logic              tx_valid,
  output logic [7:0]        tx_byte,
  input  logic              tx_ready,
  output logic              busy,
  output logic              done
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int IDX_W = $clog2(HDR_BYTES + ENT_BYTES * DEPTH + 1);

  xl_state_e         state_q;
  logic [TS_W-1:0]   tick_q;
  logic [QW-1:0]     quiet_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              ovf_q;
  logic [IDX_W-1:0]  idx_q;
  logic [STIM_W-1:0] stim_q;
  logic              done_q;

  // Named internal events, also watched by the checker.
  logic in_apply, in_cap, changed, mem_full, mem_wr;
  logic quiet_hit, ovf_hit, cap_end, tx_acc, last_byte;
  logic [QW:0]       quiet_nx, eff_lim;
  logic [IDX_W-1:0]  last_idx;
  logic [AW-1:0]     wr_addr, rd_addr;
  logic [TS_W-1:0]   wr_ts, rd_ts;
  logic [VAL_W-1:0]  rd_val;
  logic [31:0]       hdr;

  assign in_apply  = (state_q == ST_APPLY);
  assign in_cap    = (state_q == ST_CAPTURE);
  assign mem_full  = (cnt_q == CNT_W'(DEPTH));
  assign mem_wr    = in_apply || (changed && !mem_full);
  assign quiet_nx  = {1'b0, quiet_q} + (QW+1)'(1);
  assign eff_lim   = (quiet_lim == '0) ? (QW+1)'(1) : {1'b0, quiet_lim};
  assign quiet_hit = in_cap && !changed && (quiet_nx >= eff_lim);
  assign ovf_hit   = changed && mem_full;
  assign cap_end   = quiet_hit || ovf_hit;
  assign tx_valid  = (state_q == ST_SEND);
  assign tx_acc    = tx_valid && tx_ready;
  assign last_idx  = IDX_W'(stream_len(32'(cnt_q)) - 32'd1);
  assign last_byte = (idx_q == last_idx);
  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign dut_in    = stim_q;

  assign wr_addr = in_apply ? '0 : cnt_q[AW-1:0];
  assign wr_ts   = in_apply ? '0 : tick_q;
  assign rd_addr = AW'(entry_of(32'(idx_q)));
  assign hdr     = {ovf_q, {(31-CNT_W){1'b0}}, cnt_q};
  assign tx_byte = pick_byte(32'(idx_q), hdr, rd_ts, 32'(rd_val));

  xl_change_det #(.W(VAL_W)) u_det (
    .clk     (clk),
    .rst_n   (rst_n),
    .track   (in_apply || in_cap),
    .cmp     (in_cap),
    .sample  (dut_out),
    .changed (changed)
  );

  xl_event_ram #(.DEPTH(DEPTH), .AW(AW), .TW(TS_W), .VW(VAL_W)) u_ram (
    .clk     (clk),
    .wr_en   (mem_wr),
    .wr_addr (wr_addr),
    .wr_ts   (wr_ts),
    .wr_val  (dut_out),
    .rd_addr (rd_addr),
    .rd_ts   (rd_ts),
    .rd_val  (rd_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tick_q  <= '0;
      quiet_q <= '0;
      cnt_q   <= '0;
      ovf_q   <= 1'b0;
      idx_q   <= '0;
      stim_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            stim_q  <= stim;
            state_q <= ST_APPLY;
          end
        end
        ST_APPLY: begin
          tick_q  <= TS_W'(1);
          quiet_q <= '0;
          cnt_q   <= CNT_W'(1);
          ovf_q   <= 1'b0;
          idx_q   <= '0;
          state_q <= ST_CAPTURE;
        end
        ST_CAPTURE: begin
          tick_q <= sat_inc(tick_q);
          if (changed) begin
            quiet_q <= '0;
            if (!mem_full) cnt_q <= cnt_q + CNT_W'(1);
          end else begin
            quiet_q <= quiet_nx[QW-1:0];
          end
          if (ovf_hit) ovf_q <= 1'b1;
          if (cap_end) state_q <= ST_SEND;
        end
        ST_SEND: begin
          if (tx_acc) begin
            if (last_byte) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              idx_q <= idx_q + IDX_W'(1);
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xl_checker.sv
module xl_checker #(
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 5,
  parameter int STIM_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [7:0]        tx_byte,
  input logic              done,
  input logic [STIM_W-1:0] dut_in,
  input logic [CNT_W-1:0]  cnt,
  input logic              mem_wr,
  input logic              cap_end
);
  assert_first_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> mem_wr);

  assert_stream_after_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_end |=> tx_valid);

  assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH));

  assert_valid_in_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> busy);

  assert_byte_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !tx_valid));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_stim_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(dut_in));
endmodule

bind xition_logger xl_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W), .STIM_W(STIM_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .tx_byte  (tx_byte),
  .done     (done),
  .dut_in   (dut_in),
  .cnt      (cnt_q),
  .mem_wr   (mem_wr),
  .cap_end  (cap_end)
);

// File: tb/xition_logger_test.sv
module xition_logger_test;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] stim_i = '0;
  logic [15:0] quiet_i = '0;
  logic [15:0] dout = '0;
  logic        tx_ready = 1'b1;
  logic [15:0] dut_in;
  logic        tx_valid, busy, done;
  logic [7:0]  tx_byte;

  always #10 clk = ~clk;

  xition_logger #(.STIM_W(16), .VAL_W(16), .DEPTH(DEPTH), .QW(16)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .stim(stim_i), .quiet_lim(quiet_i),
    .dut_out(dout), .dut_in(dut_in), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .tx_ready(tx_ready), .busy(busy), .done(done)
  );

  int n_checks = 0;
  int n_fail   = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Output schedule: value changes to ch_v[i] from tick ch_t[i] on (tick 0 = init).
  int          ch_t [32];
  logic [15:0] ch_v [32];
  int          nch;
  logic [15:0] init_v;

  function automatic logic [15:0] val_at(input int k);
    logic [15:0] v = init_v;
    for (int i = 0; i < nch; i++)
      if (ch_t[i] != 0 && ch_t[i] <= k) v = ch_v[i];
    return v;
  endfunction

  typedef struct packed {
    logic [15:0] stim, quiet, init, t1, v1, t2, v2, t3, v3;
    logic        bp, inj;
  } row_t;

  localparam row_t ROWS [5] = '{
    '{16'h0001, 16'd3, 16'h0000, 16'd2, 16'h0012, 16'd5, 16'h0087, 16'd0, 16'h0000, 1'b0, 1'b0},
    '{16'h00A5, 16'd5, 16'hFFFF, 16'd1, 16'h00FF, 16'd3, 16'h00FF, 16'd4, 16'h8001, 1'b0, 1'b1},
    '{16'h1234, 16'd0, 16'h5A5A, 16'd0, 16'h0000, 16'd0, 16'h0000, 16'd0, 16'h0000, 1'b0, 1'b0},
    '{16'h0F0F, 16'd2, 16'h0000, 16'd1, 16'h0001, 16'd3, 16'h0000, 16'd6, 16'h0003, 1'b0, 1'b0},
    '{16'hBEEF, 16'd4, 16'h0100, 16'd7, 16'h0200, 16'd8, 16'h0300, 16'd0, 16'h0000, 1'b1, 1'b0}
  };

  task automatic run_vec(input logic [15:0] s, input logic [15:0] q, input bit bp, input bit inj);
    int          e_ts [64];
    logic [15:0] e_v  [64];
    int          ne, end_t, qc, effq, n, nb, first_n;
    bit          ovf, fin;
    logic [7:0]  got [256];
    logic [31:0] w;
    int          j, k;

    // Independent model of the expected record (R3, R4, R5, R6).
    ne = 1; e_ts[0] = 0; e_v[0] = val_at(0); ovf = 0; qc = 0; end_t = 0; fin = 0;
    effq = (q == 0) ? 1 : int'(q);
    for (int t = 1; t < 400 && !fin; t++) begin
      if (val_at(t) != val_at(t-1)) begin
        if (ne == DEPTH) begin ovf = 1; end_t = t; fin = 1; end
        else begin e_ts[ne] = t; e_v[ne] = val_at(t); ne++; qc = 0; end
      end else begin
        qc++;
        if (qc >= effq) begin end_t = t; fin = 1; end
      end
    end

    @(negedge clk);
    start = 1'b1; stim_i = s; quiet_i = q; dout = val_at(0); tx_ready = 1'b1;
    n = 0; nb = 0; first_n = -1;
    while (1) begin
      @(negedge clk);
      n++;
      if (start) start = 1'b0;
      if (done) break;
      if (n > 3000) begin chk(0, "R5 run timeout", n, 0); break; end
      if (n == 1) chk(dut_in == s, "R2 stimulus on dut_in", dut_in, s);
      dout = val_at(n - 1);
      if (tx_valid && first_n < 0) begin
        first_n = n;
        chk(n == end_t + 2, "R5/R6 capture end timing", n, end_t + 2);
        if (inj) begin start = 1'b1; stim_i = ~s; end
      end
      tx_ready = bp ? ((n % 3) != 1) : 1'b1;
      if (tx_valid && tx_ready && nb < 256) begin got[nb] = tx_byte; nb++; end
    end
    chk(!busy && !tx_valid, "R8 idle at done", {busy, tx_valid}, 0);
    chk(nb == 4 + 8*ne, "R7 stream length", nb, 4 + 8*ne);
    for (int i = 0; i < nb && i < 4 + 8*ne; i++) begin
      if (i < 4) begin
        w = {ovf, 15'b0, 16'(ne)};
        k = i;
      end else begin
        j = (i - 4) / 8; k = (i - 4) % 8;
        if (k < 4) w = 32'(e_ts[j]);
        else begin w = {16'h0, e_v[j]}; k = k - 4; end
      end
      chk(got[i] == w[8*k +: 8], (i < 4) ? "R6/R7 header byte" : "R3/R4 entry byte",
          got[i], w[8*k +: 8]);
    end
    @(negedge clk);
    chk(!done, "R8 done lasts one cycle", done, 0);
    chk(!busy && dut_in == s, "R9 start ignored while busy", {busy, dut_in}, s);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !tx_valid && !done && dut_in == 0, "R1 reset state in reset",
        {busy, tx_valid, done, dut_in}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !tx_valid && !done && dut_in == 0, "R1 reset state after release",
        {busy, tx_valid, done, dut_in}, 0);

    // Table walk.
    for (int r = 0; r < 5; r++) begin
      row_t row;
      row = ROWS[r];
      init_v = row.init; nch = 3;
      ch_t[0] = int'(row.t1); ch_v[0] = row.v1;
      ch_t[1] = int'(row.t2); ch_v[1] = row.v2;
      ch_t[2] = int'(row.t3); ch_v[2] = row.v3;
      run_vec(row.stim, row.quiet, row.bp, row.inj);
    end

    // R6: a change on every tick overruns the event store.
    init_v = 16'h5555; nch = 20;
    for (int i = 0; i < 20; i++) begin
      ch_t[i] = i + 1;
      ch_v[i] = (i % 2 == 0) ? 16'hAAAA : 16'h5555;
    end
    run_vec(16'h7777, 16'd4, 1'b0, 1'b0);

    // R6 boundary: exactly DEPTH entries, no overflow, then quiet end.
    init_v = 16'h0000; nch = DEPTH - 1;
    for (int i = 0; i < DEPTH - 1; i++) begin
      ch_t[i] = i + 1;
      ch_v[i] = 16'(i + 1);
    end
    run_vec(16'h0042, 16'd3, 1'b1, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule